// File: doc/BRIEF.md
# Video Test Pattern Generator

This block turns the pixel coordinates of a 1280x720 raster into a 24-bit RGB colour, one pixel per clock. An upstream raster timing core supplies the horizontal and vertical position of the current pixel. This block returns the colour of that pixel one clock later. A two-bit pattern select picks one of four test images: a flat white field, a flat green field, three equal vertical bands (red, green and blue), or a left-to-right ramp from black to full red.

The pattern select is taken in only at the first pixel of a frame, the pixel where both coordinates are zero. That pixel already uses the new pattern. Changes at any other time wait for the next frame, so a frame never mixes two patterns. Pixels outside the visible 1280x720 area are black.

Top module: `video_pattern_gen`

## Requirements
- R1: While reset is high and on the first clock after it, the output is 0x000000. After reset, the active pattern is white until a frame start takes in a new select.
- R2: Select code 0 (white) drives all 24 output bits to 1 for every visible pixel.
- R3: Select code 1 (green) outputs 0x00FF00 for every visible pixel. The colour is packed red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: Select code 2 (stripes) outputs 0xFF0000 for x in 0..426, 0x00FF00 for x in 427..853 and 0x0000FF for x in 854..1279, on every visible row.
- R5: Select code 3 (ramp) outputs red = floor(x*255/1279) with green and blue at 0. Red is exactly 0 at x=0, exactly 255 at x=1279, and never decreases as x grows.
- R6: Any pixel with x >= 1280 or y >= 720 outputs 0x000000, whatever the pattern.
- R7: The select is taken in only on a clock where x=0 and y=0, and it applies to that pixel. A select change at any other pixel has no effect on the output until the next such clock.
- R8: The output for the coordinates presented at a rising clock edge appears right after that edge and holds until the next edge (one register of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Pattern select: 0 white, 1 green, 2 stripes, 3 ramp |
| pix_x | input | 11 | Horizontal position of the current pixel |
| pix_y | input | 10 | Vertical position of the current pixel |
| rgb_out | output | 24 | Registered colour, {red, green, blue} |

## Verification
The stripe pattern is driven at both sides of each band edge (426/427 and 853/854) and at the last column. This tells an off-by-one in a boundary apart from a correct split. The ramp is swept over all 1280 columns and each value is compared with an exact integer division. This separates the reciprocal-multiply scheme from a truncation error that shows only on a few columns, and it also checks both end values and monotonicity. The select is changed in the middle of a frame and again at a frame start. This shows whether the select is taken at the right pixel or taken straight through. Coordinates just past the visible edge in each direction show that blanking wins over every pattern.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

    localparam int CHAN_W = 8;

    typedef enum logic [1:0] {
        PAT_WHITE   = 2'd0,
        PAT_GREEN   = 2'd1,
        PAT_STRIPES = 2'd2,
        PAT_RAMP    = 2'd3
    } pat_mode_e;

    typedef struct packed {
        logic [CHAN_W-1:0] red;
        logic [CHAN_W-1:0] grn;
        logic [CHAN_W-1:0] blu;
    } rgb_t;

    localparam logic [CHAN_W-1:0] CH_FULL = {CHAN_W{1'b1}};
    localparam logic [CHAN_W-1:0] CH_ZERO = '0;

    function automatic rgb_t mk_rgb(input logic [CHAN_W-1:0] r,
                                    input logic [CHAN_W-1:0] g,
                                    input logic [CHAN_W-1:0] b);
        rgb_t c;
        c.red = r;
        c.grn = g;
        c.blu = b;
        return c;
    endfunction

endpackage

// File: rtl/vpg_mode_latch.sv
module vpg_mode_latch
    import vpg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [1:0] mode_sel,
    input  logic      frame_start,
    output pat_mode_e eff_mode
);
    pat_mode_e held_mode;

    // The first pixel of a frame already uses the incoming select.
    always_comb begin
        eff_mode = frame_start ? pat_mode_e'(mode_sel) : held_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_mode <= PAT_WHITE;
        end else if (frame_start) begin
            held_mode <= pat_mode_e'(mode_sel);
        end
    end

    // R7: the held pattern stays fixed away from a frame start
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && !frame_start) |=> $stable(held_mode));

endmodule

// File: rtl/vpg_ramp.sv
module vpg_ramp
    import vpg_pkg::*;
#(
    parameter int XW       = 11,
    parameter int H_ACTIVE = 1280
) (
    input  logic [XW-1:0]     x,
    output logic [CHAN_W-1:0] red
);
    localparam int          DEN   = H_ACTIVE - 1;
    localparam int          MAXV  = (1 << CHAN_W) - 1;
    localparam int          SHIFT = 32;
    localparam logic [63:0] RECIP = ((64'd1 << SHIFT) + 64'(DEN) - 64'd1) / 64'(DEN);

    logic [63:0] scaled;
    logic [63:0] prod;

    always_comb begin
        scaled = 64'(x) * 64'(MAXV);
        prod   = scaled * RECIP;
        red    = prod[SHIFT +: CHAN_W];
    end

endmodule

// File: rtl/vpg_pattern_core.sv
module vpg_pattern_core
    import vpg_pkg::*;
#(
    parameter int XW       = 11,
    parameter int YW       = 10,
    parameter int H_ACTIVE = 1280,
    parameter int V_ACTIVE = 720
) (
    input  pat_mode_e     mode,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    output rgb_t          color
);
    localparam int BAND_W = (H_ACTIVE + 2) / 3;
    localparam logic [XW-1:0] EDGE_1 = XW'(BAND_W);
    localparam logic [XW-1:0] EDGE_2 = XW'(2 * BAND_W);
    localparam logic [XW-1:0] X_LIM  = XW'(H_ACTIVE);
    localparam logic [YW-1:0] Y_LIM  = YW'(V_ACTIVE);

    logic [CHAN_W-1:0] ramp_red;
    logic              visible;
    rgb_t              stripe_c;

    vpg_ramp #(.XW(XW), .H_ACTIVE(H_ACTIVE)) u_ramp (
        .x   (x),
        .red (ramp_red)
    );

    always_comb begin
        visible = (x < X_LIM) && (y < Y_LIM);
        if (x < EDGE_1)      stripe_c = mk_rgb(CH_FULL, CH_ZERO, CH_ZERO);
        else if (x < EDGE_2) stripe_c = mk_rgb(CH_ZERO, CH_FULL, CH_ZERO);
        else                 stripe_c = mk_rgb(CH_ZERO, CH_ZERO, CH_FULL);

        if (!visible) begin
            color = mk_rgb(CH_ZERO, CH_ZERO, CH_ZERO);
        end else begin
            unique case (mode)
                PAT_WHITE:   color = mk_rgb(CH_FULL, CH_FULL, CH_FULL);
                PAT_GREEN:   color = mk_rgb(CH_ZERO, CH_FULL, CH_ZERO);
                PAT_STRIPES: color = stripe_c;
                PAT_RAMP:    color = mk_rgb(ramp_red, CH_ZERO, CH_ZERO);
                default:     color = mk_rgb(CH_ZERO, CH_ZERO, CH_ZERO);
            endcase
        end
    end

endmodule

// File: rtl/video_pattern_gen.sv
module video_pattern_gen
    import vpg_pkg::*;
#(
    parameter int XW       = 11,
    parameter int YW       = 10,
    parameter int H_ACTIVE = 1280,
    parameter int V_ACTIVE = 720
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_sel,
    input  logic [XW-1:0]       pix_x,
    input  logic [YW-1:0]       pix_y,
    output logic [3*CHAN_W-1:0] rgb_out
);
    localparam logic [XW-1:0] X_LAST = XW'(H_ACTIVE - 1);

    pat_mode_e eff_mode;
    rgb_t      next_c;
    rgb_t      out_q;
    logic      frame_start;
    logic      outside;

    assign frame_start = (pix_x == '0) && (pix_y == '0);
    assign outside     = (pix_x >= XW'(H_ACTIVE)) || (pix_y >= YW'(V_ACTIVE));

    vpg_mode_latch u_mode (
        .clk         (clk),
        .rst         (rst),
        .mode_sel    (mode_sel),
        .frame_start (frame_start),
        .eff_mode    (eff_mode)
    );

    vpg_pattern_core #(
        .XW(XW), .YW(YW), .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)
    ) u_core (
        .mode  (eff_mode),
        .x     (pix_x),
        .y     (pix_y),
        .color (next_c)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= next_c;
    end

    assign rgb_out = out_q;

    // R6: blanking beats every pattern
    assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && outside) |=> (rgb_out == '0));

    // R2: white field
    assert_white_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && !outside && eff_mode == PAT_WHITE) |=> (&rgb_out));

    // R3: green field
    assert_green_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && !outside && eff_mode == PAT_GREEN) |=>
        (rgb_out == {CH_ZERO, CH_FULL, CH_ZERO}));

    // R5: ramp reaches full red on the last column
    assert_ramp_end_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && !outside && eff_mode == PAT_RAMP && pix_x == X_LAST) |=>
        (rgb_out == {CH_FULL, CH_ZERO, CH_ZERO}));

    // R5: ramp starts at black on column zero
    assert_ramp_start_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && !outside && eff_mode == PAT_RAMP && pix_x == '0) |=>
        (rgb_out == '0));

endmodule

// File: tb/tb_video_pattern_gen.sv
module tb_video_pattern_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'd0;
    logic [10:0] pix_x = '0;
    logic [9:0]  pix_y = 10'd5;
    logic [23:0] rgb_out;

    int checks   = 0;
    int failures = 0;

    video_pattern_gen dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .pix_x(pix_x), .pix_y(pix_y), .rgb_out(rgb_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] expect_rgb(input int m, input int x, input int y);
        if (x >= 1280 || y >= 720) return 24'h000000;
        case (m)
            0: return 24'hFFFFFF;
            1: return 24'h00FF00;
            2: begin
                if (x < 427) return 24'hFF0000;
                if (x < 854) return 24'h00FF00;
                return 24'h0000FF;
            end
            default: return {8'((x * 255) / 1279), 16'h0000};
        endcase
    endfunction

    task automatic check(input string req, input logic [23:0] exp);
        checks++;
        if (rgb_out !== exp) begin
            failures++;
            $display("FAIL %s: rgb_out=%06h expected=%06h", req, rgb_out, exp);
        end
    endtask

    // drive one pixel, let one edge pass, sample clear of the edge
    task automatic step(input int x, input int y);
        pix_x = 11'(x);
        pix_y = 10'(y);
        @(posedge clk);
        #1;
    endtask

    task automatic start_frame(input int m);
        mode_sel = 2'(m);
        step(0, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(100, 100);
        check("R1 during reset", 24'h000000);
        rst = 1'b0;
        step(200, 50);
        check("R1 default white after reset", 24'hFFFFFF);
    endtask

    task automatic t_white;
        start_frame(0);
        check("R2 white at origin", 24'hFFFFFF);
        step(1279, 719);
        check("R2 white at far corner", 24'hFFFFFF);
    endtask

    task automatic t_green;
        start_frame(1);
        check("R3 green at origin", 24'h00FF00);
        step(640, 360);
        check("R3 green mid screen", 24'h00FF00);
    endtask

    task automatic t_stripes;
        int xs[6] = '{0, 426, 427, 853, 854, 1279};
        start_frame(2);
        foreach (xs[i]) begin
            step(xs[i], 300);
            check("R4 stripe band edge", expect_rgb(2, xs[i], 300));
        end
        step(1000, 719);
        check("R4 stripe last row", 24'h0000FF);
    endtask

    task automatic t_ramp;
        logic [7:0] prev = 8'd0;
        start_frame(3);
        check("R5 ramp black at x=0", 24'h000000);
        for (int x = 0; x < 1280; x++) begin
            step(x, 10);
            check("R5 ramp value", expect_rgb(3, x, 10));
            checks++;
            if (rgb_out[23:16] < prev) begin
                failures++;
                $display("FAIL R5 monotonic: x=%0d red=%0d expected>=%0d", x, rgb_out[23:16], prev);
            end
            prev = rgb_out[23:16];
        end
        step(1279, 10);
        check("R5 ramp full red at x=1279", 24'hFF0000);
    endtask

    task automatic t_blank;
        start_frame(0);
        step(1280, 10);
        check("R6 x past visible", 24'h000000);
        step(10, 720);
        check("R6 y past visible", 24'h000000);
        step(2047, 1023);
        check("R6 far blank", 24'h000000);
        step(5, 5);
        check("R6 visible again", 24'hFFFFFF);
    endtask

    task automatic t_mode_timing;
        start_frame(1);
        mode_sel = 2'd2;
        step(900, 10);
        check("R7 mid-frame select ignored", 24'h00FF00);
        step(0, 1);
        check("R7 row start not frame start", 24'h00FF00);
        step(0, 0);
        check("R7 new select at frame start", 24'hFF0000);
        step(900, 10);
        check("R7 new select holds", 24'h0000FF);
    endtask

    task automatic t_latency;
        start_frame(2);
        pix_x = 11'd900;
        pix_y = 10'd10;
        #2;
        check("R8 output waits for edge", 24'hFF0000);
        @(posedge clk);
        #1;
        check("R8 output after one edge", 24'h0000FF);
        #(CLK_PERIOD - 3);
        check("R8 output held", 24'h0000FF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(posedge clk);
        #1;
        t_reset();
        t_white();
        t_green();
        t_stripes();
        t_ramp();
        t_blank();
        t_mode_timing();
        t_latency();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule